// File: doc/BRIEF.md
# Hardware Semaphore Bank

This block holds a bank of ownership words that processor cores use to gain exclusive use of a shared resource. Each word is either free, holding the value 0xFFFFFFFF, or owned, holding the identifier of the core that claimed it. A core claims a word by writing its own identifier to it, then reads the word back. The claim has succeeded if the read returns that identifier and has failed if it returns anything else. When the work on the shared resource is done, the owner frees the word by writing all ones to it.

Every core has its own write port and its own read port into a 32-bit word-addressed register space. Word n sits at byte offset 0x80 + 4·n. Writes are registered on the clock edge and reads are combinational. When several cores write to the same free word in one cycle, a fixed priority settles the contest: the core on the lowest-numbered port wins. Reads return the state registered at the most recent edge.

Top module: `sem_bank`

## Requirements
- R1: After reset every semaphore word reads 0xFFFFFFFF, the free value.
- R2: Semaphore n (0 ≤ n < NUM_SEMS) lives at byte offset 0x80 + 4·n. A read of any other offset, misaligned ones included, returns 0. A write to any other offset changes no semaphore.
- R3: A write of any value other than 0xFFFFFFFF to a free semaphore stores that value. It becomes readable from the cycle after the write edge.
- R4: A write of a value other than 0xFFFFFFFF to an owned semaphore is ignored, and the stored owner is kept.
- R5: A write of 0xFFFFFFFF from any core frees the semaphore, whoever owns it.
- R6: When several cores write claiming values to the same free semaphore in one cycle, the value from the lowest-numbered core port is stored.
- R7: When a release and a claim reach the same semaphore in one cycle, the release wins and the semaphore is free afterwards. This holds whether the semaphore was owned or free before.
- R8: Writes from different cores to different semaphores in the same cycle each take effect independently.
- R9: Every core's read port returns the current word at its address combinationally, and any core can read any semaphore.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | NUM_CORES | Write strobe, one bit per core port |
| wr_addr | input | NUM_CORES*ADDR_W | Byte offset of each core's write, port c at bits [c*ADDR_W +: ADDR_W] |
| wr_data | input | NUM_CORES*32 | Write value of each core, port c at bits [c*32 +: 32] |
| rd_addr | input | NUM_CORES*ADDR_W | Byte offset of each core's read |
| rd_data | output | NUM_CORES*32 | Read value returned to each core |

## Verification
The bench builds the block with its defaults: four core ports, 32 semaphores and a 16-bit offset. With four ports, three- and four-way contests for a single word can be tested, and so can a release and a claim that collide in one cycle. The full 32-word bank makes both edges of the address window reachable: word 0, word 31 and the first offset past the end, which must not alias back onto word 0.

// File: rtl/sem_pkg.sv
package sem_pkg;
    localparam int WORD_W = 32;
    typedef logic [WORD_W-1:0] word_t;
    localparam word_t FREE_VAL = '1;

    typedef struct packed {
        word_t owner;
    } slot_t;
endpackage

// File: rtl/sem_addr_dec.sv
module sem_addr_dec #(
    parameter int ADDR_W   = 16,
    parameter int NUM_SEMS = 32,
    parameter int BASE_OFS = 'h80,
    localparam int IDX_W   = (NUM_SEMS > 1) ? $clog2(NUM_SEMS) : 1
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic [IDX_W-1:0]  idx
);
    logic [ADDR_W-1:0] rel;

    always_comb begin
        rel = addr - ADDR_W'(BASE_OFS);
        hit = (addr >= ADDR_W'(BASE_OFS)) && (rel[1:0] == 2'b00)
              && ((rel >> 2) < ADDR_W'(NUM_SEMS));
        idx = rel[IDX_W+1:2];
    end
endmodule

// File: rtl/sem_slot.sv
module sem_slot #(
    parameter int NUM_CORES = 4
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic [NUM_CORES-1:0]                 rel_req,
    input  logic [NUM_CORES-1:0]                 acq_req,
    input  logic [NUM_CORES*sem_pkg::WORD_W-1:0] wr_data,
    output sem_pkg::word_t                       value
);
    import sem_pkg::*;

    slot_t st_d, st_q;
    word_t win_d;

    always_comb begin
        st_d  = st_q;
        win_d = FREE_VAL;
        // Walk from the top so the lowest requesting port is assigned last.
        for (int i = NUM_CORES - 1; i >= 0; i--) begin
            if (acq_req[i]) win_d = wr_data[i*WORD_W +: WORD_W];
        end
        if (|rel_req) begin
            st_d.owner = FREE_VAL;
        end else if ((st_q.owner == FREE_VAL) && (|acq_req)) begin
            st_d.owner = win_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{owner: FREE_VAL};
        else        st_q <= st_d;
    end

    assign value = st_q.owner;
endmodule

// File: rtl/sem_bank.sv
module sem_bank #(
    parameter int NUM_CORES = 4,
    parameter int NUM_SEMS  = 32,
    parameter int ADDR_W    = 16,
    parameter int BASE_OFS  = 'h80
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic [NUM_CORES-1:0]                 wr_en,
    input  logic [NUM_CORES*ADDR_W-1:0]          wr_addr,
    input  logic [NUM_CORES*sem_pkg::WORD_W-1:0] wr_data,
    input  logic [NUM_CORES*ADDR_W-1:0]          rd_addr,
    output logic [NUM_CORES*sem_pkg::WORD_W-1:0] rd_data
);
    import sem_pkg::*;

    localparam int IDX_W = (NUM_SEMS > 1) ? $clog2(NUM_SEMS) : 1;

    logic [NUM_CORES-1:0]                 wr_hit, rd_hit;
    logic [NUM_CORES-1:0][IDX_W-1:0]      wr_idx, rd_idx;
    logic [NUM_SEMS-1:0][NUM_CORES-1:0]   rel_req, acq_req;
    logic [NUM_SEMS-1:0][WORD_W-1:0]      sem_val;

    for (genvar c = 0; c < NUM_CORES; c++) begin : g_port
        sem_addr_dec #(
            .ADDR_W(ADDR_W), .NUM_SEMS(NUM_SEMS), .BASE_OFS(BASE_OFS)
        ) u_wdec (
            .addr(wr_addr[c*ADDR_W +: ADDR_W]), .hit(wr_hit[c]), .idx(wr_idx[c])
        );
        sem_addr_dec #(
            .ADDR_W(ADDR_W), .NUM_SEMS(NUM_SEMS), .BASE_OFS(BASE_OFS)
        ) u_rdec (
            .addr(rd_addr[c*ADDR_W +: ADDR_W]), .hit(rd_hit[c]), .idx(rd_idx[c])
        );
        assign rd_data[c*WORD_W +: WORD_W] = rd_hit[c] ? sem_val[rd_idx[c]] : '0;
    end

    always_comb begin
        rel_req = '0;
        acq_req = '0;
        for (int k = 0; k < NUM_SEMS; k++) begin
            for (int c = 0; c < NUM_CORES; c++) begin
                if (wr_en[c] && wr_hit[c] && (wr_idx[c] == IDX_W'(k))) begin
                    if (wr_data[c*WORD_W +: WORD_W] == FREE_VAL) rel_req[k][c] = 1'b1;
                    else                                         acq_req[k][c] = 1'b1;
                end
            end
        end
    end

    for (genvar k = 0; k < NUM_SEMS; k++) begin : g_slot
        sem_slot #(.NUM_CORES(NUM_CORES)) u_slot (
            .clk(clk), .rst_n(rst_n),
            .rel_req(rel_req[k]), .acq_req(acq_req[k]),
            .wr_data(wr_data), .value(sem_val[k])
        );
    end
endmodule

// File: rtl/sem_bank_chk.sv
module sem_bank_chk #(
    parameter int NUM_CORES = 4,
    parameter int NUM_SEMS  = 32,
    parameter int ADDR_W    = 16,
    parameter int BASE_OFS  = 'h80
) (
    input logic                                 clk,
    input logic                                 rst_n,
    input logic [NUM_CORES-1:0]                 wr_en,
    input logic [NUM_CORES*ADDR_W-1:0]          wr_addr,
    input logic [NUM_CORES*sem_pkg::WORD_W-1:0] wr_data,
    input logic [NUM_SEMS-1:0][sem_pkg::WORD_W-1:0] sem_val
);
    import sem_pkg::*;

    logic [NUM_SEMS-1:0]         any_rel, any_acq;
    logic [NUM_SEMS-1:0][WORD_W-1:0] first_val;

    always_comb begin
        any_rel   = '0;
        any_acq   = '0;
        first_val = '0;
        for (int k = 0; k < NUM_SEMS; k++) begin
            for (int c = 0; c < NUM_CORES; c++) begin
                if (wr_en[c] && (wr_addr[c*ADDR_W +: ADDR_W] == ADDR_W'(BASE_OFS + 4*k))) begin
                    if (wr_data[c*WORD_W +: WORD_W] == FREE_VAL) begin
                        any_rel[k] = 1'b1;
                    end else if (!any_acq[k]) begin
                        any_acq[k]   = 1'b1;
                        first_val[k] = wr_data[c*WORD_W +: WORD_W];
                    end
                end
            end
        end
    end

    for (genvar k = 0; k < NUM_SEMS; k++) begin : g_chk
        // R4: an owned word with no release stays put
        a_r4_owner_kept: assert property (@(posedge clk) disable iff (!rst_n)
            (sem_val[k] != FREE_VAL && !any_rel[k]) |=> $stable(sem_val[k]));
        // R5 and R7: any release leaves the word free
        a_r5_release_frees: assert property (@(posedge clk) disable iff (!rst_n)
            any_rel[k] |=> (sem_val[k] == FREE_VAL));
        // R3 and R6: a claim on a free word stores the lowest port's value
        a_r6_lowest_wins: assert property (@(posedge clk) disable iff (!rst_n)
            (sem_val[k] == FREE_VAL && any_acq[k] && !any_rel[k])
            |=> (sem_val[k] == $past(first_val[k])));
        // R2: with no write aimed at it, a free word stays free
        a_r2_idle_free: assert property (@(posedge clk) disable iff (!rst_n)
            (sem_val[k] == FREE_VAL && !any_acq[k]) |=> (sem_val[k] == FREE_VAL));
    end
endmodule

bind sem_bank sem_bank_chk #(
    .NUM_CORES(NUM_CORES), .NUM_SEMS(NUM_SEMS), .ADDR_W(ADDR_W), .BASE_OFS(BASE_OFS)
) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .sem_val(sem_val)
);

// File: tb/sem_bank_test.sv
module sem_bank_test;
    localparam int NC = 4;
    localparam int NS = 32;
    localparam int AW = 16;
    localparam logic [31:0] FREE = 32'hFFFF_FFFF;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic              rst_n;
    logic [NC-1:0]     wr_en;
    logic [NC*AW-1:0]  wr_addr, rd_addr;
    logic [NC*32-1:0]  wr_data, rd_data;
    int n_chk = 0, n_bad = 0;
    bit done = 0;

    sem_bank uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    function automatic logic [AW-1:0] sa(int n);
        return AW'(32'h80 + 4 * n);
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic put(int c, logic [AW-1:0] a, logic [31:0] d);
        wr_en[c]              = 1'b1;
        wr_addr[c*AW +: AW]   = a;
        wr_data[c*32 +: 32]   = d;
    endtask

    task automatic commit();
        @(posedge clk);
        #1;
        wr_en = '0;
    endtask

    task automatic peek(int c, logic [AW-1:0] a, output logic [31:0] v);
        rd_addr[c*AW +: AW] = a;
        #0.5;
        v = rd_data[c*32 +: 32];
    endtask

    task automatic t_reset();
        logic [31:0] v;
        for (int n = 0; n < NS; n++) begin
            peek(n % NC, sa(n), v);
            check("R1 reset free", v, FREE);
        end
    endtask

    task automatic t_claim_and_hold();
        logic [31:0] v;
        put(2, sa(5), 32'd2); commit();
        peek(0, sa(5), v); check("R3 claim free word", v, 32'd2);
        peek(3, sa(5), v); check("R9 read from other core", v, 32'd2);
        put(1, sa(5), 32'd1); commit();
        peek(1, sa(5), v); check("R4 owned word ignores claim", v, 32'd2);
        put(3, sa(5), FREE); commit();
        peek(2, sa(5), v); check("R5 release by non-owner", v, FREE);
    endtask

    task automatic t_contest();
        logic [31:0] v;
        put(3, sa(7), 32'd3); put(1, sa(7), 32'd1); put(2, sa(7), 32'd2); commit();
        peek(0, sa(7), v); check("R6 three-way contest", v, 32'd1);
        for (int c = 0; c < NC; c++) put(c, sa(8), 32'(c + 10));
        commit();
        peek(0, sa(8), v); check("R6 four-way contest", v, 32'd10);
    endtask

    task automatic t_release_vs_claim();
        logic [31:0] v;
        put(0, sa(7), FREE); put(2, sa(7), 32'd2); commit();
        peek(0, sa(7), v); check("R7 release beats claim on owned", v, FREE);
        put(3, sa(9), FREE); put(1, sa(9), 32'd1); commit();
        peek(0, sa(9), v); check("R7 release beats claim on free", v, FREE);
    endtask

    task automatic t_parallel();
        logic [31:0] v;
        put(0, sa(0), 32'h100); put(1, sa(31), 32'h101);
        put(2, sa(10), 32'h102); put(3, sa(11), 32'h103); commit();
        peek(0, sa(0), v);  check("R8 word 0", v, 32'h100);
        peek(1, sa(31), v); check("R8 word 31", v, 32'h101);
        peek(2, sa(10), v); check("R8 word 10", v, 32'h102);
        peek(3, sa(11), v); check("R8 word 11", v, 32'h103);
    endtask

    task automatic t_address();
        logic [31:0] v;
        put(0, sa(NS), 32'h55); commit();
        peek(0, sa(NS), v); check("R2 past end reads zero", v, 32'h0);
        peek(0, sa(0), v);  check("R2 past end no alias", v, 32'h100);
        put(1, sa(12) + AW'(1), 32'h5); commit();
        peek(1, sa(12), v); check("R2 misaligned write ignored", v, FREE);
        peek(1, sa(12) + AW'(2), v); check("R2 misaligned read zero", v, 32'h0);
        peek(2, AW'(16'h7C), v); check("R2 below base reads zero", v, 32'h0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #400000;
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; wr_en = '0; wr_addr = '0; wr_data = '0; rd_addr = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(posedge clk); #1;
        t_reset();
        t_claim_and_hold();
        t_contest();
        t_release_vs_claim();
        t_parallel();
        t_address();
        finish_run();
    end
endmodule